// File: doc/BRIEF.md
# Shift-Amount Register Funnel Shifter

This block is a 32-bit shift unit for a processor execute stage. A 6-bit shift-amount register sits at its centre. One group of operations loads that register: from the low bits of operand S, from the same operand scaled to bytes, from an immediate, or through a direct write port. A second group of operations produces data results. These are a funnel shift of the S:T pair, a logical right shift, an arithmetic right shift and a left shift, all driven by the stored amount, together with three shifts whose count comes from an immediate.

A left-shift amount is stored as 32 minus the requested count. With that encoding every data operation becomes one right shift of a 64-bit word by a 6-bit count. A single shared shifter core therefore serves every operation. Results are registered and come out one cycle after the operation, marked by a valid strobe. The amount register can be read at all times, and a write shows through on the read port in the same cycle.

Top module: `shamt_funnel_unit`

## Requirements
- R1: Operation 4'h1 (set for right shift) loads the amount register with opnd_s[4:0].
- R2: Operation 4'h2 (set for left shift) loads the amount register with 32 minus opnd_s[4:0]. A zero count therefore stores 32.
- R3: Operations 4'h3 and 4'h4 are the byte variants of 4'h1 and 4'h2. Each takes the low 5 bits of opnd_s multiplied by 8 as its count, that is {opnd_s[1:0],3'b000}.
- R4: Operation 4'h5 loads the amount register with imm[4:0]. imm[3:0] is the 4-bit field and imm[4] is the extra high bit.
- R5: When amt_wr_en is high, the amount register takes amt_wr_data[5:0] at the next edge. This write wins over a set operation issued in the same cycle.
- R6: Operation 4'h6 returns the low 32 bits of {opnd_s,opnd_t} shifted right by the stored amount.
- R7: Operation 4'h7 returns opnd_t zero-extended and shifted right by the stored amount. Amounts of 32 to 63 give zero.
- R8: Operation 4'h8 returns opnd_t sign-extended to 64 bits and shifted right by the stored amount. Amounts of 32 or more give 32 copies of the sign.
- R9: Operation 4'h9 returns the low 32 bits of opnd_s shifted left by (32 minus the amount) mod 64. A stored 0 gives zero, a stored 32 gives opnd_s unchanged, and amounts above 32 give zero.
- R10: Operation 4'hA shifts opnd_s left by 32 minus imm, and imm=0 gives zero. Operation 4'hB is an arithmetic right shift of opnd_t by imm. Operation 4'hC is a logical right shift of opnd_t by imm[3:0] only.
- R11: A data operation (4'h6 to 4'hC) with op_valid high updates result and pulses result_valid for exactly one cycle, on the first clock edge after issue. Set operations, 4'h0 and the unused codes 4'hD to 4'hF raise no strobe and leave result unchanged.
- R12: A synchronous active-low reset clears the amount register, result and result_valid to zero.
- R13: amt_value shows the value being written in the same cycle as a direct write or a set operation. A data operation issued in the same cycle as a direct write uses the newly written amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select |
| opnd_s | input | 32 | Operand S (upper half of funnel, left-shift source) |
| opnd_t | input | 32 | Operand T (lower half of funnel, right-shift source) |
| imm | input | 5 | Immediate count |
| amt_wr_en | input | 1 | Direct write of the amount register |
| amt_wr_data | input | 32 | Direct write value (low 6 bits kept) |
| result | output | 32 | Registered data result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| amt_value | output | 6 | Current amount, with the pending write forwarded |

## Verification
The bench targets the edges of the amount encoding.

A zero count in a left set must store 32 and not 0. Otherwise the following left shift would return zero where it should pass the operand through.

A directly written amount above 32 must drive logical and left shifts to zero and must sign-fill arithmetic shifts. A shifter that wraps the count to 5 bits would instead return shifted data.

The logical immediate shift must ignore imm[4]. The arithmetic one must use all five bits.

The bench also checks two collision cases. When a direct write and a set operation arrive in the same cycle, the write must win. When a direct write and a data operation arrive together, the data operation must use the new amount. A design without forwarding would return a result computed with the stale amount.

// File: rtl/shf_pkg.sv
// Package: shared operation codes and sizing helpers for the shift unit.
// Assumes a data width that is a power of two, so the amount register is
// one bit wider than a data-width count.
package shf_pkg;

    typedef enum logic [3:0] {
        OP_IDLE    = 4'h0,
        OP_AMT_R   = 4'h1,
        OP_AMT_L   = 4'h2,
        OP_AMT_RB  = 4'h3,
        OP_AMT_LB  = 4'h4,
        OP_AMT_IMM = 4'h5,
        OP_FUNNEL  = 4'h6,
        OP_SRL     = 4'h7,
        OP_SRA     = 4'h8,
        OP_SLL     = 4'h9,
        OP_SLLI    = 4'hA,
        OP_SRAI    = 4'hB,
        OP_SRLI    = 4'hC
    } shf_op_e;

    // True for operations that produce a data result.
    function automatic logic is_data_op(input logic [3:0] code);
        return (code >= 4'h6) && (code <= 4'hC);
    endfunction

    // True for operations that load the amount register.
    function automatic logic is_set_op(input logic [3:0] code);
        return (code >= 4'h1) && (code <= 4'h5);
    endfunction

endpackage

// File: rtl/shf_amount_reg.sv
// Module: shift-amount register with its load operations and a forwarding
// read path. Assumes at most one operation per cycle. A direct write has
// priority over a set operation issued in the same cycle.
module shf_amount_reg
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(2 * DATA_W),
    localparam int IMM_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd_s,
    input  logic [IMM_W-1:0]  imm,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [AMT_W-1:0]  amt_eff
);

    logic [AMT_W-1:0]  amt_q;
    logic [AMT_W-1:0]  set_val;
    logic              set_hit;
    logic [DATA_W-1:0] s_bytes;
    logic [IMM_W-1:0]  cnt_plain;
    logic [IMM_W-1:0]  cnt_bytes;

    // Byte-scaled count: operand times eight, truncated to a data-width count.
    always_comb begin
        s_bytes   = opnd_s << 3;
        cnt_plain = opnd_s[IMM_W-1:0];
        cnt_bytes = s_bytes[IMM_W-1:0];
    end

    // Decode the value a set operation would load.
    always_comb begin
        set_hit = op_valid && is_set_op(op_code);
        unique case (shf_op_e'(op_code))
            OP_AMT_R:   set_val = AMT_W'(cnt_plain);
            OP_AMT_L:   set_val = AMT_W'(DATA_W) - AMT_W'(cnt_plain);
            OP_AMT_RB:  set_val = AMT_W'(cnt_bytes);
            OP_AMT_LB:  set_val = AMT_W'(DATA_W) - AMT_W'(cnt_bytes);
            OP_AMT_IMM: set_val = AMT_W'(imm);
            default:    set_val = amt_q;
        endcase
    end

    // Forwarded amount: the direct write first, then a set operation, then the stored value.
    always_comb begin
        if (wr_en)
            amt_eff = wr_data[AMT_W-1:0];
        else if (set_hit)
            amt_eff = set_val;
        else
            amt_eff = amt_q;
    end

    // Amount register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            amt_q <= '0;
        else
            amt_q <= amt_eff;
    end

    assert_set_right_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en && (op_code == 4'h1)) |=> (amt_q < AMT_W'(DATA_W)));

    assert_set_left_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en && (op_code == 4'h2)) |=>
            ((amt_q >= AMT_W'(1)) && (amt_q <= AMT_W'(DATA_W))));

    assert_direct_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (amt_q == $past(wr_data[AMT_W-1:0])));

    assert_forward_lands_R13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (amt_q == $past(amt_eff)));

    assert_amt_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(op_valid && is_set_op(op_code))) |=> $stable(amt_q));

endmodule

// File: rtl/shf_operand_mux.sv
// Module: maps each data operation onto one right shift of a double-width
// word. It chooses the word, the count, the fill bit and a force-to-zero flag.
// Assumes the amount register is one bit wider than a data-width count.
module shf_operand_mux
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(2 * DATA_W),
    localparam int IMM_W = $clog2(DATA_W)
) (
    input  logic [3:0]          op_code,
    input  logic [DATA_W-1:0]   opnd_s,
    input  logic [DATA_W-1:0]   opnd_t,
    input  logic [IMM_W-1:0]    imm,
    input  logic [AMT_W-1:0]    amt,
    output logic [2*DATA_W-1:0] word,
    output logic [AMT_W-1:0]    shamt,
    output logic                fill,
    output logic                force_zero
);

    logic [DATA_W-1:0] t_sign;

    // Sign replica of T for the arithmetic shifts.
    always_comb t_sign = {DATA_W{opnd_t[DATA_W-1]}};

    // Per-operation selection of word, count and fill.
    always_comb begin
        word       = {opnd_s, opnd_t};
        shamt      = amt;
        fill       = 1'b0;
        force_zero = 1'b0;
        unique case (shf_op_e'(op_code))
            OP_FUNNEL: word = {opnd_s, opnd_t};
            OP_SRL:    word = {{DATA_W{1'b0}}, opnd_t};
            OP_SRA: begin
                word = {t_sign, opnd_t};
                fill = opnd_t[DATA_W-1];
            end
            OP_SLL: begin
                // s << (W - amt): right shift of {s, 0} by amt; beyond W nothing is left.
                word       = {opnd_s, {DATA_W{1'b0}}};
                force_zero = (amt > AMT_W'(DATA_W));
            end
            OP_SLLI: begin
                word  = {opnd_s, {DATA_W{1'b0}}};
                shamt = AMT_W'(imm);
            end
            OP_SRAI: begin
                word  = {t_sign, opnd_t};
                fill  = opnd_t[DATA_W-1];
                shamt = AMT_W'(imm);
            end
            OP_SRLI: begin
                word  = {{DATA_W{1'b0}}, opnd_t};
                shamt = AMT_W'(imm[IMM_W-2:0]);
            end
            default: force_zero = 1'b1;
        endcase
    end

endmodule

// File: rtl/shf_funnel_core.sv
// Module: logarithmic right shifter of a double-width word. It returns the low
// half. Vacated bits take the fill value. One stage per bit of the count.
module shf_funnel_core #(
    parameter int DATA_W = 32,
    localparam int WORD_W = 2 * DATA_W,
    localparam int AMT_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [AMT_W-1:0]  shamt,
    input  logic              fill,
    output logic [DATA_W-1:0] low_out
);

    logic [WORD_W-1:0] stage [AMT_W+1];

    // Stage zero is the unshifted word.
    always_comb stage[0] = word;

    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        // Shift by 2^i when count bit i is set.
        always_comb begin
            if (shamt[i])
                stage[i+1] = {{STEP{fill}}, stage[i][WORD_W-1:STEP]};
            else
                stage[i+1] = stage[i];
        end
    end

    // The low half of the last stage is the result.
    always_comb low_out = stage[AMT_W][DATA_W-1:0];

endmodule

// File: rtl/shamt_funnel_unit.sv
// Module: top of the shift unit. It holds the amount register, maps each
// operation onto the shared funnel core and registers the result with a
// one-cycle valid strobe. Assumes one operation per cycle.
module shamt_funnel_unit
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(2 * DATA_W),
    localparam int IMM_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd_s,
    input  logic [DATA_W-1:0] opnd_t,
    input  logic [IMM_W-1:0]  imm,
    input  logic              amt_wr_en,
    input  logic [DATA_W-1:0] amt_wr_data,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic [AMT_W-1:0]  amt_value
);

    logic [AMT_W-1:0]    amt_eff;
    logic [2*DATA_W-1:0] word;
    logic [AMT_W-1:0]    shamt;
    logic                fill;
    logic                force_zero;
    logic [DATA_W-1:0]   shifted;
    logic                data_go;

    shf_amount_reg #(.DATA_W(DATA_W)) u_amt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .opnd_s   (opnd_s),
        .imm      (imm),
        .wr_en    (amt_wr_en),
        .wr_data  (amt_wr_data),
        .amt_eff  (amt_eff)
    );

    shf_operand_mux #(.DATA_W(DATA_W)) u_mux (
        .op_code    (op_code),
        .opnd_s     (opnd_s),
        .opnd_t     (opnd_t),
        .imm        (imm),
        .amt        (amt_eff),
        .word       (word),
        .shamt      (shamt),
        .fill       (fill),
        .force_zero (force_zero)
    );

    shf_funnel_core #(.DATA_W(DATA_W)) u_core (
        .word    (word),
        .shamt   (shamt),
        .fill    (fill),
        .low_out (shifted)
    );

    // Amount read port carries the forwarded value.
    always_comb amt_value = amt_eff;

    // A data operation is accepted this cycle.
    always_comb data_go = op_valid && is_data_op(op_code);

    // Result register with its one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= data_go;
            if (data_go)
                result <= force_zero ? '0 : shifted;
        end
    end

    assert_valid_from_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(op_valid && is_data_op(op_code)));

    assert_idle_holds_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && is_data_op(op_code)) |=> ($stable(result) && !result_valid));

    assert_srl_wide_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'h7) && (amt_value >= AMT_W'(DATA_W))) |=> (result == '0));

    assert_sra_keeps_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'h8)) |=> (result[DATA_W-1] == $past(opnd_t[DATA_W-1])));

    assert_sll_wide_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'h9) && (amt_value == '0)) |=> (result == '0));

endmodule

// File: tb/shamt_funnel_unit_test.sv
// Bench: walks a vector table of operations with expected amounts and results,
// then runs directed tests for reset, forwarding, collisions and wide amounts.
module shamt_funnel_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'h0;
    logic [31:0] opnd_s = '0;
    logic [31:0] opnd_t = '0;
    logic [4:0]  imm = '0;
    logic        amt_wr_en = 1'b0;
    logic [31:0] amt_wr_data = '0;
    logic [31:0] result;
    logic        result_valid;
    logic [5:0]  amt_value;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    shamt_funnel_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .op_code      (op_code),
        .opnd_s       (opnd_s),
        .opnd_t       (opnd_t),
        .imm          (imm),
        .amt_wr_en    (amt_wr_en),
        .amt_wr_data  (amt_wr_data),
        .result       (result),
        .result_valid (result_valid),
        .amt_value    (amt_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Row: {op[4], s[32], t[32], imm[5], exp_amt[6], exp_res[32], has_res[1]}
    localparam logic [111:0] VEC [NVEC] = '{
        {4'h1, 32'h0000_0024, 32'h0, 5'h00, 6'd4,  32'h0,         1'b0}, // R1
        {4'h6, 32'h0000_00AB, 32'h1234_5678, 5'h00, 6'd4,  32'hB123_4567, 1'b1}, // R6
        {4'h7, 32'h0, 32'h8000_0000, 5'h00, 6'd4,  32'h0800_0000, 1'b1}, // R7
        {4'h8, 32'h0, 32'h8000_0000, 5'h00, 6'd4,  32'hF800_0000, 1'b1}, // R8
        {4'h2, 32'h0000_0008, 32'h0, 5'h00, 6'd24, 32'h0,         1'b0}, // R2
        {4'h9, 32'h0000_00FF, 32'h0, 5'h00, 6'd24, 32'h0000_FF00, 1'b1}, // R9
        {4'h2, 32'h0000_0020, 32'h0, 5'h00, 6'd32, 32'h0,         1'b0}, // R2 zero count
        {4'h9, 32'h1234_5678, 32'h0, 5'h00, 6'd32, 32'h1234_5678, 1'b1}, // R9
        {4'h7, 32'h0, 32'hFFFF_FFFF, 5'h00, 6'd32, 32'h0,         1'b1}, // R7
        {4'h8, 32'h0, 32'h8000_0001, 5'h00, 6'd32, 32'hFFFF_FFFF, 1'b1}, // R8
        {4'h6, 32'hCAFE_F00D, 32'h1, 5'h00, 6'd32, 32'hCAFE_F00D, 1'b1}, // R6
        {4'h3, 32'h0000_0003, 32'h0, 5'h00, 6'd24, 32'h0,         1'b0}, // R3
        {4'h6, 32'h0000_0011, 32'h2233_4455, 5'h00, 6'd24, 32'h0000_1122, 1'b1}, // R6
        {4'h4, 32'h0000_0001, 32'h0, 5'h00, 6'd24, 32'h0,         1'b0}, // R3
        {4'h4, 32'h0000_0004, 32'h0, 5'h00, 6'd32, 32'h0,         1'b0}, // R3
        {4'h5, 32'h0, 32'h0, 5'h13, 6'd19, 32'h0,                 1'b0}, // R4
        {4'h7, 32'h0, 32'h8000_0000, 5'h00, 6'd19, 32'h0000_1000, 1'b1}, // R7
        {4'hA, 32'h0000_0001, 32'h0, 5'h1F, 6'd19, 32'h0000_0002, 1'b1}, // R10
        {4'hA, 32'hFFFF_FFFF, 32'h0, 5'h00, 6'd19, 32'h0,         1'b1}, // R10
        {4'hB, 32'h0, 32'h8000_0000, 5'h1F, 6'd19, 32'hFFFF_FFFF, 1'b1}, // R10
        {4'hC, 32'h0, 32'h8000_0000, 5'h1F, 6'd19, 32'h0001_0000, 1'b1}, // R10
        {4'hB, 32'h0, 32'h4000_0000, 5'h1E, 6'd19, 32'h0000_0001, 1'b1}  // R10
    };

    // Requirement tag for an operation code.
    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'h1: return "R1";
            4'h2: return "R2";
            4'h3, 4'h4: return "R3";
            4'h5: return "R4";
            4'h6: return "R6";
            4'h7: return "R7";
            4'h8: return "R8";
            4'h9: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Compare and count one check.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation for one cycle, then return to idle at the next negedge.
    task automatic issue(input logic [3:0] op, input logic [31:0] s, input logic [31:0] t,
                         input logic [4:0] im, input logic wr, input logic [31:0] wd);
        @(negedge clk);
        op_valid = (op != 4'h0);
        op_code = op; opnd_s = s; opnd_t = t; imm = im;
        amt_wr_en = wr; amt_wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'h0; amt_wr_en = 1'b0;
        #1;
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R12: reset state
        check("R12", {26'h0, amt_value}, 32'h0);
        check("R12", result, 32'h0);
        check("R12", {31'h0, result_valid}, 32'h0);
        rst_n = 1'b1;

        // Vector table walk.
        for (int i = 0; i < NVEC; i++) begin
            logic [111:0] v;
            v = VEC[i];
            issue(v[111:108], v[107:76], v[75:44], v[43:39], 1'b0, 32'h0);
            check(req_of(v[111:108]), {26'h0, amt_value}, {26'h0, v[38:33]});
            if (v[0]) begin
                check(req_of(v[111:108]), result, v[32:1]);
                check("R11", {31'h0, result_valid}, 32'h1);
            end
        end

        // R11: strobe lasts one cycle
        @(negedge clk); #1;
        check("R11", {31'h0, result_valid}, 32'h0);

        // R11: set op and unused code leave result and strobe untouched
        held = result;
        issue(4'h1, 32'h0000_0007, 32'h0, 5'h0, 1'b0, 32'h0);
        check("R11", result, held);
        check("R11", {31'h0, result_valid}, 32'h0);
        issue(4'hE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'h1F, 1'b0, 32'h0);
        check("R11", result, held);
        check("R11", {31'h0, result_valid}, 32'h0);
        check("R11", {26'h0, amt_value}, 32'd7);

        // R13: forwarding visible during the write cycle
        @(negedge clk);
        amt_wr_en = 1'b1; amt_wr_data = 32'h0000_0FE8;
        #1;
        check("R13", {26'h0, amt_value}, 32'd40);
        @(posedge clk);
        @(negedge clk);
        amt_wr_en = 1'b0;
        #1;
        check("R5", {26'h0, amt_value}, 32'd40);

        // Wide amounts: 40
        issue(4'h9, 32'hFFFF_FFFF, 32'h0, 5'h0, 1'b0, 32'h0);
        check("R9", result, 32'h0);
        issue(4'h7, 32'h0, 32'hFFFF_FFFF, 5'h0, 1'b0, 32'h0);
        check("R7", result, 32'h0);
        issue(4'h8, 32'h0, 32'h8000_0000, 5'h0, 1'b0, 32'h0);
        check("R8", result, 32'hFFFF_FFFF);
        issue(4'h6, 32'h8000_0000, 32'h0, 5'h0, 1'b0, 32'h0);
        check("R6", result, 32'h0080_0000);

        // R9: stored zero gives zero
        issue(4'h0, 32'h0, 32'h0, 5'h0, 1'b1, 32'h0000_0040);
        check("R5", {26'h0, amt_value}, 32'd0);
        issue(4'h9, 32'hFFFF_FFFF, 32'h0, 5'h0, 1'b0, 32'h0);
        check("R9", result, 32'h0);

        // R5: direct write beats a set op in the same cycle
        issue(4'h1, 32'h0000_0009, 32'h0, 5'h0, 1'b1, 32'h0000_0003);
        check("R5", {26'h0, amt_value}, 32'd3);

        // R13: data op with simultaneous write uses the new amount
        issue(4'h7, 32'h0, 32'h0000_0100, 5'h0, 1'b1, 32'h0000_0008);
        check("R13", result, 32'h0000_0001);
        check("R13", {26'h0, amt_value}, 32'd8);

        // R12: mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk); #1;
        check("R12", {26'h0, amt_value}, 32'h0);
        check("R12", result, 32'h0);
        check("R12", {31'h0, result_valid}, 32'h0);
        rst_n = 1'b1;

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule